// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block is the read side of a bit-serial configuration store. An SRAM-based FPGA loading in master serial mode reads its image from it. The array holds `DEPTH_BITS` bits, written a byte at a time through a synchronous load port. During read-out, an address counter steps through the array on each configuration clock edge. The current bit is presented on a data pin with a separate drive enable, so the pin can be tri-stated.

Several instances can share one data line. Each device's chip-enable-out goes to the chip-enable of the next device. When a device has shifted out its last bit, it releases the line and enables its successor in the same cycle, so the combined stream has no gap.

A combined reset/output-enable input clears the counter at its reset level and enables the output at its other level. The polarity of that input is chosen by a strap that is captured during the power-on sequence. A serial-enable input selects between read-out mode and programming mode.

Top module: `cfg_serial_mem`

## Requirements
- R1: While read mode is active and the reset/output-enable input is at its reset level, the next edge clears the address and end state. The data driver stays off whatever chip enable does.
- R2: With chip enable low and output enable active, every clock edge advances the address by one and the data driver is on. The bit at the current address is on `data_o` before the edge that advances past it, including address 0.
- R3: With chip enable high, the address holds, the data driver is off whatever the output enable level, and `standby_o` is high (read mode, after power-up).
- R4: The edge that consumes the last address latches an end state. From then on `ceo_no` is low and the device's own driver stays off, so the next device can drive the line.
- R5: In the end state, `ceo_no` is low while chip enable is low and output enable is active, and follows chip enable while output enable stays active. It returns high when output enable is deasserted and stays high until the whole array has been read again.
- R6: After `rst_ni` is released, `ready_o` stays low for `POR_CYCLES` clock edges, then stays high. The address starts at 0.
- R7: `pol_i` is sampled on each edge while `ready_o` is low and is then frozen. With `pol_i`=0 a low `rst_oe_i` is the reset level and a high `rst_oe_i` enables output. With `pol_i`=1 the levels are swapped.
- R8: With `ser_en_i` low the device is in programming mode: no counting, no drive, chip enable has no effect. The load port writes byte `load_addr_i` only in this mode; a load with `ser_en_i` high leaves the array unchanged.
- R9: Address a reads bit 7-(a mod 8) of byte a/8, so each byte goes out MSB first. The address saturates at the last bit and nothing is driven past it.
- R10: Two devices chained through `ceo_no` onto one line are never both driving. Together they produce the first device's image followed by the second device's image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| pol_i | input | 1 | Reset polarity strap, sampled while not ready |
| ser_en_i | input | 1 | High: read mode; low: programming mode |
| ce_ni | input | 1 | Chip enable, active low |
| rst_oe_i | input | 1 | Combined reset / output enable |
| load_en_i | input | 1 | Byte write strobe (programming mode only) |
| load_addr_i | input | $clog2(DEPTH_BITS/8) | Byte address for writes |
| load_data_i | input | 8 | Byte to write |
| data_o | output | 1 | Serial data bit |
| data_oe_o | output | 1 | Drive enable for data_o |
| ceo_no | output | 1 | Chip enable out, active low |
| standby_o | output | 1 | Standby indication |
| ready_o | output | 1 | Power-on sequence complete |

## Verification
The properties assume that `pol_i` is stable around the end of the power-on sequence. They also assume that all control inputs change only between clock edges, and that a downstream device's chip enable comes from the upstream `ceo_no`. The bench changes every input one time unit after a rising edge and loads images only with `ser_en_i` low, except for one deliberate write with `ser_en_i` high that must be ignored. The second device's chip enable is wired only to the first device's `ceo_no`.

// File: rtl/cfg_mem_pkg.sv
package cfg_mem_pkg;
  typedef enum logic {
    POL_RST_LOW  = 1'b0,
    POL_RST_HIGH = 1'b1
  } rst_pol_e;

  // reset level of the combined pin under the selected polarity
  function automatic logic at_reset_level(rst_pol_e pol, logic pin);
    return (pol == POL_RST_HIGH) ? pin : ~pin;
  endfunction
endpackage

// File: rtl/cfg_por_seq.sv
module cfg_por_seq
  import cfg_mem_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pol_i,
  output logic     ready_o,
  output rst_pol_e pol_o
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(POR_CYCLES);

  logic [CW-1:0] cnt_q;
  rst_pol_e      pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pol_q <= POL_RST_LOW;
    end else begin
      if (cnt_q != CNT_DONE) begin
        cnt_q <= cnt_q + 1'b1;
        pol_q <= rst_pol_e'(pol_i);
      end
    end
  end

  assign ready_o = (cnt_q == CNT_DONE);
  assign pol_o   = pol_q;
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int unsigned DEPTH_BITS = 1024,
  localparam int unsigned BYTES = DEPTH_BITS / 8,
  localparam int unsigned AW    = $clog2(DEPTH_BITS),
  localparam int unsigned BAW   = $clog2(BYTES)
) (
  input  logic           clk_i,
  input  logic           wr_en_i,
  input  logic [BAW-1:0] wr_addr_i,
  input  logic [7:0]     wr_data_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic           rd_bit_o
);
  logic [7:0] mem_q [BYTES];
  logic [7:0] rd_byte;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_byte  = mem_q[rd_addr_i[AW-1:3]];
  // MSB first: bit index 7-k is the bitwise inverse of k
  assign rd_bit_o = rd_byte[~rd_addr_i[2:0]];
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int unsigned DEPTH_BITS = 1024,
  localparam int unsigned AW = $clog2(DEPTH_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          end_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH_BITS - 1);

  logic [AW-1:0] addr_q;
  logic          end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      end_q  <= 1'b0;
    end else if (clr_i) begin
      addr_q <= '0;
      end_q  <= 1'b0;
    end else if (adv_i && !end_q) begin
      if (addr_q == LAST) end_q  <= 1'b1;
      else                addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign end_o  = end_q;
endmodule

// File: rtl/cfg_out_gate.sv
module cfg_out_gate (
  input  logic read_en_i,
  input  logic ce_ni,
  input  logic oe_act_i,
  input  logic end_i,
  output logic adv_o,
  output logic drive_o,
  output logic ceo_no,
  output logic standby_o
);
  logic sel;

  assign sel       = read_en_i && !ce_ni && oe_act_i;
  assign adv_o     = sel;
  assign drive_o   = sel && !end_i;
  assign ceo_no    = !(sel && end_i);
  assign standby_o = read_en_i && ce_ni;
endmodule

// File: rtl/cfg_serial_mem.sv
module cfg_serial_mem
  import cfg_mem_pkg::*;
#(
  parameter int unsigned DEPTH_BITS = 1024,
  parameter int unsigned POR_CYCLES = 8,
  localparam int unsigned BYTES = DEPTH_BITS / 8,
  localparam int unsigned AW    = $clog2(DEPTH_BITS),
  localparam int unsigned BAW   = $clog2(BYTES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pol_i,
  input  logic           ser_en_i,
  input  logic           ce_ni,
  input  logic           rst_oe_i,
  input  logic           load_en_i,
  input  logic [BAW-1:0] load_addr_i,
  input  logic [7:0]     load_data_i,
  output logic           data_o,
  output logic           data_oe_o,
  output logic           ceo_no,
  output logic           standby_o,
  output logic           ready_o
);
  rst_pol_e      pol_q;
  logic          read_en, rst_lvl, adv, end_q, rd_bit;
  logic [AW-1:0] addr_q;

  cfg_por_seq #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pol_i  (pol_i),
    .ready_o(ready_o),
    .pol_o  (pol_q)
  );

  assign read_en = ready_o && ser_en_i;
  assign rst_lvl = at_reset_level(pol_q, rst_oe_i);

  cfg_out_gate u_gate (
    .read_en_i(read_en),
    .ce_ni    (ce_ni),
    .oe_act_i (!rst_lvl),
    .end_i    (end_q),
    .adv_o    (adv),
    .drive_o  (data_oe_o),
    .ceo_no   (ceo_no),
    .standby_o(standby_o)
  );

  cfg_addr_ctr #(.DEPTH_BITS(DEPTH_BITS)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (read_en && rst_lvl),
    .adv_i (adv),
    .addr_o(addr_q),
    .end_o (end_q)
  );

  cfg_bit_store #(.DEPTH_BITS(DEPTH_BITS)) u_store (
    .clk_i    (clk_i),
    .wr_en_i  (load_en_i && !ser_en_i),
    .wr_addr_i(load_addr_i),
    .wr_data_i(load_data_i),
    .rd_addr_i(addr_q),
    .rd_bit_o (rd_bit)
  );

  assign data_o = data_oe_o ? rd_bit : 1'b0;
endmodule

// File: rtl/cfg_serial_mem_chk.sv
module cfg_serial_mem_chk #(
  parameter int unsigned DEPTH_BITS = 1024,
  localparam int unsigned AW = $clog2(DEPTH_BITS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ser_en_i,
  input logic          ce_ni,
  input logic          rst_oe_i,
  input logic          data_oe_o,
  input logic          ceo_no,
  input logic          standby_o,
  input logic          ready_o,
  input logic          pol_q,
  input logic [AW-1:0] addr_q,
  input logic          end_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH_BITS - 1);

  logic rl, rd;
  assign rl = pol_q ? rst_oe_i : !rst_oe_i;
  assign rd = ready_o && ser_en_i;

  AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && rl) |=> (addr_q == '0 && !end_q)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !rl && !ce_ni && !end_q && addr_q != LAST) |=> (addr_q == AW'($past(addr_q) + 1'b1))); // R2
  AST_STANDBY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !rl && ce_ni) |=> $stable(addr_q)); // R3
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !data_oe_o); // R3
  AST_END_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> !data_oe_o); // R4
  AST_CEO_NEEDS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> end_q); // R5
  AST_READY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R6
  AST_POL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> $stable(pol_q)); // R7
  AST_PROG_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !ser_en_i) |=> ($stable(addr_q) && $stable(end_q))); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |-> (addr_q == LAST)); // R9
endmodule

bind cfg_serial_mem cfg_serial_mem_chk #(.DEPTH_BITS(DEPTH_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ser_en_i (ser_en_i),
  .ce_ni    (ce_ni),
  .rst_oe_i (rst_oe_i),
  .data_oe_o(data_oe_o),
  .ceo_no   (ceo_no),
  .standby_o(standby_o),
  .ready_o  (ready_o),
  .pol_q    (pol_q),
  .addr_q   (addr_q),
  .end_q    (end_q)
);

// File: tb/cfg_serial_mem_test.sv
module cfg_serial_mem_test;
  localparam int DB  = 64;
  localparam int NB  = DB / 8;
  localparam int POR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol = 1'b0, ser_en = 1'b0, ce_n = 1'b1, rst_oe = 1'b0;
  logic [1:0] ld_en = '0;
  logic [2:0] ld_addr = '0;
  logic [7:0] ld_data = '0;

  logic d_a, oe_a, ceo_a, sb_a, rdy_a;
  logic d_b, oe_b, ceo_b, sb_b, rdy_b;

  always #5 clk = ~clk;

  cfg_serial_mem #(.DEPTH_BITS(DB), .POR_CYCLES(POR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pol_i(pol), .ser_en_i(ser_en), .ce_ni(ce_n),
    .rst_oe_i(rst_oe), .load_en_i(ld_en[0]), .load_addr_i(ld_addr), .load_data_i(ld_data),
    .data_o(d_a), .data_oe_o(oe_a), .ceo_no(ceo_a), .standby_o(sb_a), .ready_o(rdy_a));

  cfg_serial_mem #(.DEPTH_BITS(DB), .POR_CYCLES(POR)) nxt (
    .clk_i(clk), .rst_ni(rst_n), .pol_i(pol), .ser_en_i(ser_en), .ce_ni(ceo_a),
    .rst_oe_i(rst_oe), .load_en_i(ld_en[1]), .load_addr_i(ld_addr), .load_data_i(ld_data),
    .data_o(d_b), .data_oe_o(oe_b), .ceo_no(ceo_b), .standby_o(sb_b), .ready_o(rdy_b));

  logic line;
  assign line = oe_a ? d_a : (oe_b ? d_b : 1'b0);

  // behavioural reference state
  logic [7:0] img [2][NB];
  int pos [2];
  bit endf [2];
  int por_cnt;
  bit pol_m;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  string stream_got = "", stream_exp = "";

  function automatic bit bit_at(int d, int p);
    return img[d][p / 8][7 - (p % 8)];
  endfunction

  function automatic bit rst_level();
    return pol_m ? rst_oe : !rst_oe;
  endfunction

  function automatic bit rd_mode();
    return (por_cnt >= POR) && ser_en;
  endfunction

  function automatic bit sel_of(bit ce);
    return rd_mode() && !ce && !rst_level();
  endfunction

  function automatic bit ceo_exp_a();
    return !(sel_of(ce_n) && endf[0]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_cnt = 0; pol_m = 0;
      for (int d = 0; d < 2; d++) begin pos[d] = 0; endf[d] = 0; end
    end else begin
      bit ce_v [2];
      bit rd, rl;
      ce_v[0] = ce_n; ce_v[1] = ceo_exp_a();
      rd = rd_mode(); rl = rst_level();
      for (int d = 0; d < 2; d++) begin
        if (rd && rl) begin pos[d] = 0; endf[d] = 0; end
        else if (rd && !ce_v[d] && !rl && !endf[d]) begin
          if (pos[d] == DB - 1) endf[d] = 1; else pos[d]++;
        end
        if (ld_en[d] && !ser_en) img[d][ld_addr] = ld_data;
      end
      if (por_cnt < POR) begin pol_m = pol; por_cnt++; end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit oa, ob, ca, cb, rd;
    string tg;
    rd = rd_mode();
    ca = ce_n; oa = sel_of(ca) && !endf[0];
    cb = ceo_exp_a(); ob = sel_of(cb) && !endf[1];
    if (!ser_en) tg = "R8"; else if (rst_level()) tg = "R1";
    else if (ca) tg = "R3"; else tg = "R2";
    chk({tg, " oe_a"}, oe_a, oa);
    chk("R10 oe_b", oe_b, ob);
    chk("R5 ceo_a", ceo_a, cb);
    chk("R4 ceo_b", ceo_b, !(sel_of(cb) && endf[1]));
    chk("R3 standby", sb_a, rd && ca);
    chk("R6 ready", rdy_a, por_cnt >= POR);
    chk("R10 one driver", oe_a && oe_b, 1'b0);
    if (oa) chk("R9 data_a", line, bit_at(0, pos[0]));
    if (ob) chk("R9 data_b", line, bit_at(1, pos[1]));
    if (oe_a || oe_b) stream_got = {stream_got, line ? "1" : "0"};
    if (oa || ob) stream_exp = {stream_exp, (oa ? bit_at(0, pos[0]) : bit_at(1, pos[1])) ? "1" : "0"};
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(int d, int a, logic [7:0] v);
    ld_en = '0; ld_en[d] = 1'b1; ld_addr = 3'(a); ld_data = v;
    step(1);
    ld_en = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;                 // R6: ready low for POR edges
    step(POR + 2);
    // R8: programming mode, load both images
    for (int i = 0; i < NB; i++) begin
      load(0, i, 8'(8'hA5 ^ (i * 37)));
      load(1, i, 8'(8'h3C + i * 19));
    end
    ser_en = 1'b1;
    load(0, 0, 8'h00);            // R8: ignored in read mode
    rst_oe = 1'b1; ce_n = 1'b1;   // R3: standby, frozen
    step(4);
    ce_n = 1'b0;                  // R2/R4/R10: read both devices
    step(2 * DB + 6);
    ce_n = 1'b1; step(2);         // R5: ceo follows ce in end state
    ce_n = 1'b0; step(2);
    rst_oe = 1'b0; step(2);       // R1/R5: reset, ceo high
    ce_n = 1'b1; rst_oe = 1'b1; step(2);
    ce_n = 1'b0; step(10);
    ser_en = 1'b0; step(3);       // R8: frozen mid-stream
    ser_en = 1'b1; step(DB);
    ce_n = 1'b1; rst_oe = 1'b0; step(2);
    // R7: swapped polarity
    rst_n = 1'b0; pol = 1'b1; step(2);
    rst_n = 1'b1; step(POR + 1);
    rst_oe = 1'b1; ce_n = 1'b0; step(3);  // reset level now high
    rst_oe = 1'b0; step(DB + 8);
    rst_oe = 1'b1; step(2);
    n_cmp++;
    if (stream_got != stream_exp) begin
      n_bad++;
      $display("FAIL R10 stream actual=%s expected=%s", stream_got, stream_exp);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule